// File: doc/BRIEF.md
# Stack-Relative Move and Push Unit

This unit carries out two data-movement operations against a 4096-byte, byte-addressed data memory. It keeps a 12-bit frame pointer. A one-word push stores an 8-bit literal at the address in the pointer and then steps the pointer down by one. A two-word relative move reads the byte at pointer plus a 7-bit source offset and writes it to pointer plus a 7-bit destination offset. Every address sum and every pointer step wraps modulo 4096. A parameter list names the indirect-access addresses. A read from one of them yields zero, and a move aimed at one of them writes nothing. A second list names protected addresses, and the move never writes to those.

Instruction words enter on a valid/ready stream. The unit takes a word only in a cycle where `in_valid` and `in_ready` are both high. `in_word` must stay stable while `in_valid` is high and `in_ready` is low. The upstream side may hold `in_valid` low for any number of cycles. One clock cycle stands for one instruction cycle. In that cycle the four phases (decode, operand, process, memory access) are folded into the decode and address logic in front of the memory port. The memory port is synchronous: a read issued in one cycle returns `mem_rdata` on the next cycle. After a move's first word the unit drops `in_ready` for one cycle. In that cycle it captures the source byte. It then takes the destination word.

Top module: `stack_rel_mover`

## Requirements
- R1: While reset is held and in the first cycle after it, `frame_ptr` is 000h, `done` is 0, `in_ready` is 1, and `mem_rd_en` and `mem_wr_en` stay 0 unless a word is offered.
- R2: A word whose bits 15:8 equal FAh is a push. In its accept cycle the unit drives `mem_wr_en`=1, `mem_addr`=`frame_ptr` and `mem_wdata`=bits 7:0. After that edge `frame_ptr` is one lower, and 000h becomes FFFh.
- R3: A word whose bits 15:7 equal 1_1101_0111b is a move's first word. In its accept cycle the unit issues a read at (`frame_ptr` + bits 6:0) mod 4096. `in_ready` is then 0 for exactly the next cycle.
- R4: The next word accepted after a move's first word is the destination word. Bits 15:7 are ignored and bits 6:0 give the destination offset. The captured byte is written to (`frame_ptr` + offset) mod 4096, and `frame_ptr` does not change.
- R5: If the source address is an indirect-access address (default FDBh–FDFh, FE3h–FE7h, FEBh–FEFh), the byte that is moved is 00h.
- R6: If the destination address is an indirect-access address, the move performs no write.
- R7: If the destination address is a protected address (default FF9h, FFDh, FFEh, FFFh), the move performs no write. A push to these addresses still writes.
- R8: Any other word accepted while idle is a no-operation: no memory read or write and no change to the pointer.
- R9: `done` is high for one cycle, in the cycle after the edge that accepts a push, a no-operation or a move's destination word. It stays low after a move's first word.
- R10: While `in_valid` is low the unit leaves memory and the pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 16 | Instruction word |
| mem_addr | output | 12 | Memory byte address |
| mem_rd_en | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| frame_ptr | output | 12 | Current frame pointer |
| done | output | 1 | One-cycle strobe at the end of each instruction |

## Verification
The assertions check the cycle-level rules on every cycle. Each push moves the pointer down by exactly one, and the pointer holds otherwise. Every read is followed by one cycle of stall. Read and write never occur together. Every write is followed by a `done` strobe. The bench scenarios are what show the data behaviour: moved values matching a reference memory, source masking to zero, destination writes dropped at indirect and protected addresses, and address wrap-around. A cycle-by-cycle property cannot express these without repeating the address lists and the memory contents.

// File: rtl/stack_rel_pkg.sv
package stack_rel_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int WORD_W = 16;
  localparam int OFF_W  = 7;

  localparam logic [7:0] PUSH_OPC  = 8'hFA;
  localparam logic [8:0] MOVE1_OPC = 9'b1_1101_0111;

  localparam int DEF_N_IND = 15;
  localparam logic [DEF_N_IND*ADDR_W-1:0] DEF_IND_LIST = {
    12'hFDB, 12'hFDC, 12'hFDD, 12'hFDE, 12'hFDF,
    12'hFE3, 12'hFE4, 12'hFE5, 12'hFE6, 12'hFE7,
    12'hFEB, 12'hFEC, 12'hFED, 12'hFEE, 12'hFEF};

  localparam int DEF_N_PROT = 4;
  localparam logic [DEF_N_PROT*ADDR_W-1:0] DEF_PROT_LIST = {
    12'hFF9, 12'hFFD, 12'hFFE, 12'hFFF};

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DEST  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/stack_rel_addr_match.sv
module stack_rel_addr_match #(
  parameter int AW = 12,
  parameter int N  = 4,
  parameter logic [N*AW-1:0] LIST = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [N-1:0] hits;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = (addr == LIST[i*AW +: AW]);
  end

  assign hit = |hits;
endmodule

// File: rtl/stack_rel_ptr.sv
module stack_rel_ptr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_en,
  output logic [AW-1:0] ptr
);
  localparam int HI_W = AW - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  logic            borrow;

  assign borrow = (lo_q == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (dec_en) begin
      lo_q <= lo_q - 8'd1;
      if (borrow) hi_q <= hi_q - {{(HI_W-1){1'b0}}, 1'b1};
    end
  end

  assign ptr = {hi_q, lo_q};

  assert_ptr_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> ptr == $past(ptr) - {{(AW-1){1'b0}}, 1'b1});

  assert_ptr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> $stable(ptr));
endmodule

// File: rtl/stack_rel_mover.sv
module stack_rel_mover
  import stack_rel_pkg::*;
#(
  parameter int N_IND  = DEF_N_IND,
  parameter logic [N_IND*ADDR_W-1:0] IND_LIST = DEF_IND_LIST,
  parameter int N_PROT = DEF_N_PROT,
  parameter logic [N_PROT*ADDR_W-1:0] PROT_LIST = DEF_PROT_LIST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] frame_ptr,
  output logic              done
);
  seq_state_t        state_q;
  logic [DATA_W-1:0] src_byte_q;
  logic              src_ind_q;
  logic              done_q;

  logic              accept, is_push, is_move1;
  logic              push_fire, move1_fire, dest_fire, nop_fire;
  logic              ind_hit, prot_hit;
  logic [ADDR_W-1:0] off_addr;

  assign in_ready = (state_q != ST_FETCH);
  assign accept   = in_valid && in_ready;
  assign is_push  = (in_word[WORD_W-1 -: 8] == PUSH_OPC);
  assign is_move1 = (in_word[WORD_W-1 -: 9] == MOVE1_OPC);

  assign push_fire  = accept && (state_q == ST_IDLE) && is_push;
  assign move1_fire = accept && (state_q == ST_IDLE) && is_move1;
  assign nop_fire   = accept && (state_q == ST_IDLE) && !is_push && !is_move1;
  assign dest_fire  = accept && (state_q == ST_DEST);

  // One adder serves both offsets: source in idle, destination in the dest state.
  assign off_addr = frame_ptr + {{(ADDR_W-OFF_W){1'b0}}, in_word[OFF_W-1:0]};

  stack_rel_addr_match #(.AW(ADDR_W), .N(N_IND), .LIST(IND_LIST)) u_ind_match (
    .addr (off_addr),
    .hit  (ind_hit)
  );

  stack_rel_addr_match #(.AW(ADDR_W), .N(N_PROT), .LIST(PROT_LIST)) u_prot_match (
    .addr (off_addr),
    .hit  (prot_hit)
  );

  stack_rel_ptr #(.AW(ADDR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec_en (push_fire),
    .ptr    (frame_ptr)
  );

  assign mem_rd_en = move1_fire;
  assign mem_wr_en = push_fire || (dest_fire && !ind_hit && !prot_hit);
  assign mem_addr  = push_fire ? frame_ptr : off_addr;
  assign mem_wdata = push_fire ? in_word[DATA_W-1:0] : src_byte_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      src_byte_q <= '0;
      src_ind_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= push_fire || dest_fire || nop_fire;
      unique case (state_q)
        ST_IDLE: if (move1_fire) begin
          state_q   <= ST_FETCH;
          src_ind_q <= ind_hit;
        end
        ST_FETCH: begin
          src_byte_q <= src_ind_q ? '0 : mem_rdata;
          state_q    <= ST_DEST;
        end
        ST_DEST: if (dest_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_stall_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !in_ready);

  assert_ready_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  assert_single_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done);

  assert_no_done_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !done);
endmodule

// File: tb/test_stack_rel_mover.sv
`timescale 1ns/1ps
module test_stack_rel_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [11:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [11:0] frame_ptr;
  logic        done;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [11:0] last_rd_addr = '0;
  bit finished = 0;

  logic [7:0]  mem     [4096];
  logic [7:0]  ref_mem [4096];
  logic [11:0] ref_ptr = '0;

  always #2 clk = ~clk;

  stack_rel_mover i_stack_rel_mover (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .frame_ptr(frame_ptr), .done(done)
  );

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      last_rd_addr <= mem_addr;
    end
    if (rst_n && mem_wr_en) wr_cnt++;
    if (rst_n && mem_rd_en) rd_cnt++;
  end

  function automatic bit is_ind(input logic [11:0] a);
    case (a)
      12'hFDB, 12'hFDC, 12'hFDD, 12'hFDE, 12'hFDF,
      12'hFE3, 12'hFE4, 12'hFE5, 12'hFE6, 12'hFE7,
      12'hFEB, 12'hFEC, 12'hFED, 12'hFEE, 12'hFEF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_prot(input logic [11:0] a);
    return (a == 12'hFF9) || (a == 12'hFFD) || (a == 12'hFFE) || (a == 12'hFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] k);
    logic [11:0] a;
    int w0;
    a = ref_ptr;
    w0 = wr_cnt;
    ref_mem[a] = k;
    ref_ptr = ref_ptr - 12'd1;
    issue({8'hFA, k});
    chk(mem[a] == k, "R2 push data", mem[a], k);
    chk(frame_ptr == ref_ptr, "R2 pointer step", frame_ptr, ref_ptr);
    chk(wr_cnt == w0 + 1, "R2 one write", wr_cnt, w0 + 1);
    chk(done == 1'b1, "R9 done after push", done, 1);
  endtask

  task automatic do_move(input logic [6:0] zs, input logic [6:0] zd, input logic [8:0] junk);
    logic [11:0] s, d;
    logic [7:0]  v;
    bit wr;
    int w0;
    s = ref_ptr + {5'd0, zs};
    d = ref_ptr + {5'd0, zd};
    v = is_ind(s) ? 8'h00 : ref_mem[s];
    wr = !is_ind(d) && !is_prot(d);
    issue({9'b1_1101_0111, zs});
    chk(last_rd_addr == s, "R3 source address", last_rd_addr, s);
    chk(in_ready == 1'b0, "R3 stall cycle", in_ready, 0);
    chk(done == 1'b0, "R9 no done after first word", done, 0);
    w0 = wr_cnt;
    if (wr) ref_mem[d] = v;
    issue({junk, zd});
    if (!wr && is_ind(d))
      chk(wr_cnt == w0, "R6 indirect dest no write", wr_cnt, w0);
    else if (!wr)
      chk(wr_cnt == w0, "R7 protected dest no write", wr_cnt, w0);
    else if (is_ind(s))
      chk(mem[d] == 8'h00, "R5 masked source", mem[d], 0);
    else
      chk(mem[d] == v, "R4 moved byte", mem[d], v);
    chk(mem[d] == ref_mem[d], "R4 dest contents", mem[d], ref_mem[d]);
    chk(frame_ptr == ref_ptr, "R4 pointer unchanged", frame_ptr, ref_ptr);
    chk(done == 1'b1, "R9 done after move", done, 1);
  endtask

  task automatic do_nop(input logic [15:0] w);
    int w0, r0;
    w0 = wr_cnt;
    r0 = rd_cnt;
    issue(w);
    chk(wr_cnt == w0 && rd_cnt == r0, "R8 no memory access", wr_cnt + rd_cnt, w0 + r0);
    chk(frame_ptr == ref_ptr, "R8 pointer kept", frame_ptr, ref_ptr);
    chk(done == 1'b1, "R9 done after nop", done, 1);
  endtask

  function automatic logic [6:0] aim(input logic [11:0] base, input bit want_ind);
    logic [11:0] tgt, diff;
    tgt  = want_ind ? 12'hFDB + 12'($urandom_range(0, 20)) : 12'hFF9 + 12'($urandom_range(0, 6));
    diff = tgt - base;
    return (diff < 12'd128) ? diff[6:0] : 7'($urandom_range(0, 127));
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    mem[5] = 8'h33; ref_mem[5] = 8'h33;
    mem[6] = 8'h11; ref_mem[6] = 8'h11;
    repeat (4) @(negedge clk);
    chk(frame_ptr == 12'h000, "R1 reset pointer", frame_ptr, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(!mem_wr_en && !mem_rd_en, "R1 reset no access", mem_wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_ptr == 12'h000 && done == 1'b0, "R1 after release", frame_ptr, 0);

    do_move(7'h05, 7'h06, 9'h1E0);
    chk(mem[6] == 8'h33, "R4 worked copy", mem[6], 8'h33);
    do_nop(16'hF123);
    do_nop(16'h0000);

    begin
      int w0;
      w0 = wr_cnt;
      repeat (6) @(negedge clk);
      chk(frame_ptr == ref_ptr && wr_cnt == w0, "R10 idle holds", wr_cnt, w0);
    end

    do_push(8'h08);
    chk(frame_ptr == 12'hFFF, "R2 wrap to FFF", frame_ptr, 12'hFFF);
    do_move(7'h00, 7'h00, 9'h1FF);
    do_move(7'h02, 7'h7F, 9'h000);

    for (int n = 0; n < 700; n++) begin
      int pick;
      pick = $urandom_range(0, 99);
      if (pick < 50) begin
        do_push(8'($urandom));
      end else if (pick < 85) begin
        logic [6:0] zs, zd;
        zs = ($urandom_range(0, 2) == 0) ? aim(ref_ptr, 1'b1) : 7'($urandom);
        zd = ($urandom_range(0, 1) == 0) ? aim(ref_ptr, $urandom_range(0, 1) == 0) : 7'($urandom);
        do_move(zs, zd, 9'($urandom));
      end else begin
        logic [15:0] w;
        w = 16'($urandom);
        while (w[15:8] == 8'hFA || w[15:7] == 9'b1_1101_0111) w = 16'($urandom);
        do_nop(w);
      end
      if ($urandom_range(0, 9) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R4 final memory image", bad, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule